// File: doc/BRIEF.md
# Edge-Resynchronized Clock Divider with Half-Cycle Alignment

The block divides a fast system clock by a power of two with a free-running phase counter and hands out the divided clock as a pair of half-period bits. The high-half bit is meant for the half that starts at the rising system-clock edge and the low-half bit for the half that starts at the falling edge. A dual-edge output register placed after the block turns the pair into a single pin. With the default 5-bit counter, a 336 MHz system clock gives a 10.5 MHz output.

An external reference is sampled on both system-clock edges. When it rises, the counter is reloaded to a fixed phase, so the divided clock follows the reference with a known latency. When the falling-edge sample is the first to see the reference high, the high-half bit can take a one-cycle-delayed copy of the counter's top bit. This moves the output edge by half a system-clock period. A run-time enable picks between this half-cycle alignment and plain whole-cycle alignment, and no reset is needed to switch.

Time here is counted in half-periods ("slots") of the system clock. The sampling instant of a reference edge is the clock edge, rising or falling, at which the first high sample was taken.

Top module: `edge_sync_divider`

## Requirements
- R1: With no rising reference edge, the output is periodic with a period of 2**CNT_W system cycles (32 by default). Each period is high for 16 cycles and low for 16 cycles. This holds both after reset and after each re-alignment.
- R2: The reference is sampled at every rising and every falling clock edge. A rising edge is the first sample that reads 1 after a sample that read 0, taken in time order. Its phase is the clock edge that took that sample. Falling reference edges and constant levels do not re-align the counter.
- R3: A rising reference edge first seen by a rising-clock-edge sample makes the output rise 8 slots after the sampling instant, in either mode. This rise lands in a high half (clk_hi_o).
- R4: With ddr_en_i = 1, a rising reference edge first seen by a falling-clock-edge sample makes the output rise 8 slots after the sampling instant, in a low half (clk_lo_o = 1 while clk_hi_o = 0). Whenever the two halves differ, the high half repeats the low half of the previous pair.
- R5: With ddr_en_i = 0, both halves of every pair are equal. A rising reference edge first seen by a falling-clock-edge sample makes the output rise 7 slots after the sampling instant.
- R6: Changing ddr_en_i takes effect on the following output pairs without reset or re-alignment. After falling-phase alignment, turning it off moves the next free-running rise one slot earlier.
- R7: Reset is synchronous and active low. Both outputs are 0 in the cycle after reset was sampled. After release the counter starts from zero, so the first output rise comes 16 cycles after the first clock edge with rst_ni = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock; both edges are used |
| rst_ni | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | External reference the divided clock is aligned to |
| ddr_en_i | input | 1 | 1: half-cycle alignment, 0: whole-cycle alignment |
| clk_hi_o | output | 1 | Output value for the half starting at the rising clock edge |
| clk_lo_o | output | 1 | Output value for the half starting at the falling clock edge |

## Verification
The embedded assertions check on every cycle:
- that a reported edge agrees with the reference sampled two edges earlier;
- that a reload is followed by the low-then-high output step;
- that the two halves differ only when the high half repeats the previous low half;
- that the halves are equal whenever DDR mode is off;
- that the outputs are cleared by reset.

Only the bench's scenarios can show the absolute timing against the reference: rise times measured in slots for random sub-cycle offsets in both modes, the 50% duty and period, the ignored falling edges, and the one-slot shift when the enable is toggled at run time.

// File: rtl/esd_pkg.sv
// Shared types and helpers for the edge-resynchronized divider.
// Assumes: a counter width of at least 2 bits.
package esd_pkg;

    // Which system-clock edge took the first high sample of a reference edge
    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } samp_phase_e;

    // Counter value loaded on a reference edge: one count below the output-bit rise
    function automatic int reload_phase(input int width);
        return (1 << (width - 1)) - 1;
    endfunction

endpackage

// File: rtl/esd_ref_sampler.sv
// Dual-edge reference sampler and rising-edge detector.
// Samples ref_i on both clock edges and retimes both samples into the rising-edge domain.
// An edge is flagged when a sample reads 1 and the sample just before it in time reads 0.
// Assumes: ref_i is already synchronous enough to be sampled (no metastability filter here).
module esd_ref_sampler (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic ev_pos_o,
    output logic ev_neg_o
);

    logic samp_pos_q;   // taken at rising edge k
    logic samp_neg_q;   // taken at falling edge k
    logic pos_d_q;      // retimed rising sample of pair k
    logic neg_d_q;      // retimed falling sample of pair k
    logic neg_dd_q;     // falling sample of pair k-1

    // Capture the reference at the rising clock edge
    always_ff @(posedge clk_i) begin
        if (!rst_ni) samp_pos_q <= 1'b0;
        else         samp_pos_q <= ref_i;
    end

    // Capture the reference at the falling clock edge
    always_ff @(negedge clk_i) begin
        if (!rst_ni) samp_neg_q <= 1'b0;
        else         samp_neg_q <= ref_i;
    end

    // Align both samples of one pair, plus the previous falling sample, to the rising edge
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pos_d_q  <= 1'b0;
            neg_d_q  <= 1'b0;
            neg_dd_q <= 1'b0;
        end else begin
            pos_d_q  <= samp_pos_q;
            neg_d_q  <= samp_neg_q;
            neg_dd_q <= neg_d_q;
        end
    end

    // Time-ordered comparison: each sample against the one half a cycle before it
    always_comb begin
        ev_pos_o = pos_d_q & ~neg_dd_q;
        ev_neg_o = neg_d_q & ~pos_d_q;
    end

    // R2: a rising-phase edge means the reference was high at the rising edge two cycles back
    assert_pos_event_sampled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_pos_o |-> $past(ref_i, 2));

    // R2: a falling-phase edge means the rising-edge sample of the same pair was low
    assert_neg_event_sampled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_neg_o |-> !$past(ref_i, 2));

endmodule

// File: rtl/esd_phase_counter.sv
// Free-running phase counter with reload on reference edges.
// Keeps the live counter, a copy delayed by one cycle and the phase of the last alignment.
// Assumes: at most one of ev_pos_i / ev_neg_i is high in any cycle.
module esd_phase_counter
    import esd_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ev_pos_i,
    input  logic        ev_neg_i,
    output logic        live_bit_o,
    output logic        dly_bit_o,
    output samp_phase_e sync_ph_o
);

    localparam int              MSB    = CNT_W - 1;
    localparam logic [MSB:0]    RELOAD = CNT_W'(reload_phase(CNT_W));
    localparam logic [MSB:0]    ONE    = CNT_W'(1);

    logic [MSB:0] cnt_q;
    logic [MSB:0] cnt_dq;
    samp_phase_e  sync_ph_q;

    // Advance the phase, or jump to the reload value on a reference edge
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                 cnt_q <= '0;
        else if (ev_pos_i || ev_neg_i) cnt_q <= RELOAD;
        else                         cnt_q <= cnt_q + ONE;
    end

    // One-cycle-delayed copy of the counter for the half-cycle path
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_dq <= '0;
        else         cnt_dq <= cnt_q;
    end

    // Remember which clock edge caught the last reference edge
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       sync_ph_q <= PH_POS;
        else if (ev_neg_i) sync_ph_q <= PH_NEG;
        else if (ev_pos_i) sync_ph_q <= PH_POS;
    end

    always_comb begin
        live_bit_o = cnt_q[MSB];
        dly_bit_o  = cnt_dq[MSB];
        sync_ph_o  = sync_ph_q;
    end

endmodule

// File: rtl/esd_out_pair.sv
// Output pair register feeding an external dual-edge output stage.
// The low half always shows the live phase bit. The high half shows the delayed bit
// only after falling-phase alignment with DDR enabled.
// Assumes: ddr_en_i is static for at least one cycle around a change (no glitch filter).
module esd_out_pair
    import esd_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ddr_en_i,
    input  logic        live_bit_i,
    input  logic        dly_bit_i,
    input  samp_phase_e sync_ph_i,
    output logic        out_hi_o,
    output logic        out_lo_o
);

    logic use_dly;

    // Pick the delayed bit for the first half only in half-cycle mode
    always_comb use_dly = ddr_en_i && (sync_ph_i == PH_NEG);

    // Register both halves of the next output pair
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_hi_o <= 1'b0;
            out_lo_o <= 1'b0;
        end else begin
            out_hi_o <= use_dly ? dly_bit_i : live_bit_i;
            out_lo_o <= live_bit_i;
        end
    end

    // R5: with DDR off both halves of the pair carry the same value
    assert_ddr_off_equal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ddr_en_i |=> (out_hi_o == out_lo_o));

endmodule

// File: rtl/edge_sync_divider.sv
// Top: divides clk_i by 2**CNT_W and aligns the result to rising edges of ref_i
// with half-cycle resolution. Outputs are a half-period pair for a dual-edge output register.
// Assumes: ref_i period is well above a few system cycles; reset held for at least two cycles.
module edge_sync_divider
    import esd_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    input  logic ddr_en_i,
    output logic clk_hi_o,
    output logic clk_lo_o
);

    logic        ev_pos;
    logic        ev_neg;
    logic        ev_any;
    logic        live_bit;
    logic        dly_bit;
    samp_phase_e sync_ph;

    esd_ref_sampler u_samp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ref_i    (ref_i),
        .ev_pos_o (ev_pos),
        .ev_neg_o (ev_neg)
    );

    esd_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ev_pos_i   (ev_pos),
        .ev_neg_i   (ev_neg),
        .live_bit_o (live_bit),
        .dly_bit_o  (dly_bit),
        .sync_ph_o  (sync_ph)
    );

    esd_out_pair u_out (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ddr_en_i   (ddr_en_i),
        .live_bit_i (live_bit),
        .dly_bit_i  (dly_bit),
        .sync_ph_i  (sync_ph),
        .out_hi_o   (clk_hi_o),
        .out_lo_o   (clk_lo_o)
    );

    // Any detected reference edge, used only by the checks below
    always_comb ev_any = ev_pos | ev_neg;

    // R3: an isolated reload gives a low pair, then a high low-half on the next pair
    assert_reload_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_any ##1 !ev_any) |=> (!clk_lo_o ##1 clk_lo_o));

    // R4: halves differ only when the high half repeats the previous low half
    assert_half_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_hi_o != clk_lo_o) |-> (clk_hi_o == $past(clk_lo_o)));

    // R7: reset clears both outputs
    assert_reset_clear_R7: assert property (@(posedge clk_i)
        $past(!rst_ni) |-> (!clk_hi_o && !clk_lo_o));

endmodule

// File: tb/sim_edge_sync_divider.sv
`timescale 1ps/1ps
// Bench: measures output rise and fall times in picoseconds and compares them with
// times derived from the requirements. Clock 250 MHz (4000 ps), slot = 2000 ps.
module sim_edge_sync_divider;

    localparam longint PER  = 4000;
    localparam longint SLOT = 2000;

    logic clk = 1'b0;
    logic rst_n;
    logic ref_s;
    logic ddr;
    logic clk_hi;
    logic clk_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    longint rise_t [64];
    longint fall_t [64];
    int     rn = 0;
    int     fn = 0;
    logic   prev_lo = 1'b0;

    edge_sync_divider u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .ref_i    (ref_s),
        .ddr_en_i (ddr),
        .clk_hi_o (clk_hi),
        .clk_lo_o (clk_lo)
    );

    always #(PER / 2) clk = ~clk;

    function automatic bit has_ev(input bit rising, input longint t);
        for (int i = 0; i < 64; i++) begin
            if (rising && rise_t[i] == t) return 1'b1;
            if (!rising && fall_t[i] == t) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Expected rise time from the pulse launch time and its sub-cycle offset
    function automatic longint exp_rise(input longint tp, input int dly, input bit ddr_on);
        longint n_edges;
        longint ts;
        n_edges = longint'((dly + 1999) / 2000);
        ts      = tp + n_edges * SLOT;
        if (!ddr_on && n_edges == 1) return ts + 7 * SLOT;   // falling-phase edge, DDR off
        return ts + 8 * SLOT;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Build the output waveform slot by slot and log every edge
    always @(posedge clk) begin : mon
        longint tm;
        tm = $time;
        #1000;
        if (!rst_n) begin
            prev_lo = 1'b0;
        end else begin
            if (!prev_lo && clk_hi) begin rise_t[rn % 64] = tm; rn++; end
            else if (prev_lo && !clk_hi) begin fall_t[fn % 64] = tm; fn++; end
            if (!clk_hi && clk_lo) begin rise_t[rn % 64] = tm + SLOT; rn++; end
            else if (clk_hi && !clk_lo) begin fall_t[fn % 64] = tm + SLOT; fn++; end
            prev_lo = clk_lo;
        end
    end

    task automatic trial(input int dly, input bit ddr_v, input string req, output longint e);
        longint tp;
        ddr = ddr_v;
        @(posedge clk);
        tp = $time;
        #(dly);
        ref_s = 1'b1;
        e = exp_rise(tp, dly, ddr_v);
        repeat (10) @(posedge clk);
        #300 ref_s = 1'b0;
        repeat (30) @(posedge clk);
        #1500;
        chk(has_ev(1'b1, e), req, 0, e);
        chk(has_ev(1'b0, e + 16 * PER), "R1 duty after align", 0, e + 16 * PER);
        chk(has_ev(1'b1, e + 32 * PER), "R1/R2 period, falling ref ignored", 0, e + 32 * PER);
    endtask

    initial begin
        longint trel;
        longint e;
        int     seed_dummy;
        seed_dummy = int'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 64; i++) begin rise_t[i] = -1; fall_t[i] = -1; end
        rst_n = 1'b0;
        ref_s = 1'b0;
        ddr   = 1'b1;
        repeat (3) @(posedge clk);
        #1000;
        // R7: outputs cleared during reset
        chk(clk_hi == 1'b0, "R7 reset hi", longint'(clk_hi), 0);
        chk(clk_lo == 1'b0, "R7 reset lo", longint'(clk_lo), 0);
        @(posedge clk);
        #500 rst_n = 1'b1;
        @(posedge clk);
        trel = $time;
        repeat (55) @(posedge clk);
        #1500;
        // R7: counter restarts from zero; R1: free-running duty and period
        chk(has_ev(1'b1, trel + 16 * PER), "R7 first rise after reset", 0, trel + 16 * PER);
        chk(has_ev(1'b0, trel + 32 * PER), "R1 free-run fall", 0, trel + 32 * PER);
        chk(has_ev(1'b1, trel + 48 * PER), "R1 free-run period", 0, trel + 48 * PER);

        // Directed corners: each phase in each mode, and offsets near the edges
        trial(1000, 1'b1, "R4 falling-phase DDR on", e);
        trial(3000, 1'b1, "R3 rising-phase DDR on", e);
        trial(1000, 1'b0, "R5 falling-phase DDR off", e);
        trial(3000, 1'b0, "R3 rising-phase DDR off", e);
        trial(1900, 1'b1, "R4 late falling-phase", e);
        trial(2100, 1'b1, "R3 early rising-phase", e);
        trial(100,  1'b0, "R5 early falling-phase", e);
        trial(3900, 1'b1, "R3 late rising-phase", e);

        // R6: turn DDR off after falling-phase alignment, without reset
        trial(1000, 1'b1, "R4 before toggle", e);
        ddr = 1'b0;
        repeat (36) @(posedge clk);
        #1500;
        chk(has_ev(1'b1, e + 64 * PER - SLOT), "R6 rise one slot earlier", 0, e + 64 * PER - SLOT);
        chk(!has_ev(1'b1, e + 64 * PER), "R6 old rise gone", e + 64 * PER, 0);
        ddr = 1'b1;

        // Random offsets and modes
        for (int i = 0; i < 24; i++) begin
            int  d;
            int  m;
            bit  md;
            d  = 100 + int'($urandom % 3800);
            m  = d % 2000;
            if (m < 150) d = d + 300;
            else if (m > 1850) d = d - 300;
            md = bit'($urandom % 2);
            repeat (int'($urandom % 7)) @(posedge clk);
            trial(d, md, (d < 2000) ? (md ? "R4 random" : "R5 random") : "R3 random", e);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule